// File: doc/BRIEF.md
# Dual-Source Receive Gain Controller

This block holds the 5-bit gain code for a receive amplifier chain and decides where that code comes from. Gain codes run from 0 (lowest gain, -6 dB) to 21 (highest gain, +36 dB), one code per 2 dB step. The code can be set in one of two ways:

- A write to the gain register over the serial configuration interface.
- A pin-mode capture, which takes five data pins on a clock edge where a gain strobe pin is sampled high.

A source-select bit held in the register chooses which of the two paths is live.

The block always presents the gain that is actually in effect. It drives that gain on the amplifier control output, and a register read returns the same value. The read returns the applied code whichever path wrote it.

When the wideband receive filter is selected, the highest usable gain is 30 dB, which is code 18. Stored codes above 18 then act as 18. The stored code itself is kept, so turning wideband off brings the original gain back without a rewrite.

Top module: `rx_gain_ctrl`

## Requirements
- R1: While reset is asserted, and afterwards until the first write, the stored code is 0, pin mode is selected (select bit 0), `ampGain` is 0 and `regRdData` is 6'h00.
- R2: A register write with `regWrData[5]`=1 selects register mode and stores `regWrData[4:0]`. The new code appears on `ampGain` after that clock edge.
- R3: In pin mode (select bit 0), a rising clock edge with `gainPin` high captures `gainBus[4:0]` as the new code.
- R4: The pins do not change the code in two cases: when `gainPin` is low, and at any time in register mode.
- R5: A register write with `regWrData[5]`=0 switches to pin mode and leaves the stored code unchanged.
- R6: A code above 21 (5'h15) is stored as 21, whichever path supplied it.
- R7: While `wideband` is 1, a stored code above 18 (5'h12) is presented as 18. Codes of 18 or less pass unchanged.
- R8: Clearing `wideband` presents the unclamped stored code again, in the same cycle, with no rewrite.
- R9: `regRdData` is {select bit, applied code}: bit 5 is the source select and bits 4:0 always equal `ampGain`.
- R10: If a register write and a pin strobe arrive in the same cycle, the register write wins and the pin strobe is ignored for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Gain register write strobe |
| regWrData | input | 6 | Write data: bit 5 is the source select, bits 4:0 are the gain code |
| gainPin | input | 1 | Pin-mode capture strobe |
| gainBus | input | 5 | Pin-mode gain code |
| wideband | input | 1 | Wideband filter selected, which limits the gain |
| regRdData | output | 6 | Readback: {source select, applied code} |
| ampGain | output | 5 | Applied gain code to the amplifier |

## Verification
Checked on every cycle by assertions:
- The stored code never exceeds 21.
- The output never exceeds 18 while wideband is set.
- The output follows the stored code exactly while wideband is clear.
- A code is held in register mode unless a write loads it.
- A pin capture lands when one is enabled.
- The two load strobes are never active together.

Shown only by the bench's scenarios:
- Ordered sequences: switching modes by a write that keeps the code, and a same-cycle conflict between the two sources.
- The stored code reappearing after wideband clears.
- The exact readback word, including the select bit.

// File: rtl/rxg_pkg.sv
package rxg_pkg;

  parameter int unsigned GAIN_W = 5;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic loadReg;   // take the code from the register write data
    logic loadPin;   // take the code from the gain pins
    logic setSel;    // update the source-select bit
    logic selVal;    // new value of the source-select bit
  } gainStrobe_t;

  // Limit a raw code to the highest legal code.
  function automatic logic [GAIN_W-1:0] satCode(
    input logic [GAIN_W-1:0] raw,
    input logic [GAIN_W-1:0] maxCode
  );
    return (raw > maxCode) ? maxCode : raw;
  endfunction

endpackage

// File: rtl/rxg_ctrl.sv
module rxg_ctrl
  import rxg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regWrSel,
  input  logic        gainPin,
  output gainStrobe_t strobe,
  output logic        selReg
);

  // Decide which source loads the code this cycle.
  // A register write has priority over a pin strobe (R10).
  always_comb begin
    strobe.setSel  = regWrEn;
    strobe.selVal  = regWrSel;
    strobe.loadReg = regWrEn & regWrSel;
    strobe.loadPin = ~regWrEn & ~selReg & gainPin;
  end

  // The source select resets to pin mode (R1).
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg <= 1'b0;
    end else if (strobe.setSel) begin
      selReg <= strobe.selVal;
    end
  end

  // R10: at most one of the two sources loads the code in a cycle.
  a_r10_one_source: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadReg, strobe.loadPin}));

  // R4: in register mode, a pin strobe never turns into a load.
  a_r4_pin_blocked: assert property (@(posedge clk) disable iff (!rstN)
    selReg |-> !strobe.loadPin);

  // R2 and R5: a register write sets the select bit for the next cycle.
  a_r2_sel_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (selReg == $past(regWrSel)));

endmodule

// File: rtl/rxg_datapath.sv
module rxg_datapath
  import rxg_pkg::*;
#(
  parameter int unsigned MAX_CODE = 21,
  parameter int unsigned WB_CODE  = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  gainStrobe_t       strobe,
  input  logic [GAIN_W-1:0] regCode,
  input  logic [GAIN_W-1:0] pinCode,
  input  logic              wideband,
  output logic [GAIN_W-1:0] storedCode,
  output logic [GAIN_W-1:0] ampGain
);

  localparam logic [GAIN_W-1:0] MaxC = GAIN_W'(MAX_CODE);
  localparam logic [GAIN_W-1:0] WbC  = GAIN_W'(WB_CODE);

  logic [GAIN_W-1:0] srcCode;
  logic [GAIN_W-1:0] nextCode;
  logic              overLimit;

  // Choose the source, then saturate it before storing (R6).
  always_comb begin
    srcCode  = strobe.loadReg ? regCode : pinCode;
    nextCode = satCode(srcCode, MaxC);
  end

  // The code register resets to the lowest gain (R1).
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      storedCode <= '0;
    end else if (strobe.loadReg || strobe.loadPin) begin
      storedCode <= nextCode;
    end
  end

  // Apply the wideband limit at the output only, so the stored
  // code survives (R7, R8).
  always_comb begin
    overLimit = wideband && (storedCode > WbC);
    ampGain   = overLimit ? WbC : storedCode;
  end

  // R6: the stored code never exceeds the highest legal code.
  a_r6_code_in_range: assert property (@(posedge clk) disable iff (!rstN)
    storedCode <= MaxC);

  // R7: the applied gain stays at or below the wideband limit.
  a_r7_wb_limit: assert property (@(posedge clk) disable iff (!rstN)
    wideband |-> (ampGain <= WbC));

  // R8: with wideband clear, the applied gain equals the stored code.
  a_r8_no_clamp: assert property (@(posedge clk) disable iff (!rstN)
    !wideband |-> (ampGain == storedCode));

  // R3: a legal pin code is captured exactly.
  a_r3_pin_capture: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadPin && (pinCode <= MaxC)) |=> (storedCode == $past(pinCode)));

  // R4 and R5: the code is held when neither source loads it.
  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.loadReg || strobe.loadPin) |=> $stable(storedCode));

endmodule

// File: rtl/rx_gain_ctrl.sv
module rx_gain_ctrl
  import rxg_pkg::*;
#(
  parameter int unsigned MAX_CODE = 21,
  parameter int unsigned WB_CODE  = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [GAIN_W:0]   regWrData,
  input  logic              gainPin,
  input  logic [GAIN_W-1:0] gainBus,
  input  logic              wideband,
  output logic [GAIN_W:0]   regRdData,
  output logic [GAIN_W-1:0] ampGain
);

  gainStrobe_t       strobe;
  logic              selReg;
  logic [GAIN_W-1:0] storedCode;

  rxg_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regWrSel (regWrData[GAIN_W]),
    .gainPin  (gainPin),
    .strobe   (strobe),
    .selReg   (selReg)
  );

  rxg_datapath #(
    .MAX_CODE (MAX_CODE),
    .WB_CODE  (WB_CODE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .regCode    (regWrData[GAIN_W-1:0]),
    .pinCode    (gainBus),
    .wideband   (wideband),
    .storedCode (storedCode),
    .ampGain    (ampGain)
  );

  // Readback: the source select and the gain actually applied (R9).
  assign regRdData = {selReg, ampGain};

  // R1: right after reset the code is zero and pin mode is selected.
  a_r1_reset_state: assert property (@(posedge clk)
    !rstN |=> (storedCode == '0 && !selReg) || !rstN);

endmodule

// File: tb/rx_gain_ctrl_bench.sv
module rx_gain_ctrl_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [5:0] regWrData = '0;
  logic       gainPin = 1'b0;
  logic [4:0] gainBus = '0;
  logic       wideband = 1'b0;
  logic [5:0] regRdData;
  logic [4:0] ampGain;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // 250 MHz clock: 4 ns period.
  always #2 clk = ~clk;

  rx_gain_ctrl u_rx_gain_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .gainPin   (gainPin),
    .gainBus   (gainBus),
    .wideband  (wideband),
    .regRdData (regRdData),
    .ampGain   (ampGain)
  );

  // Vector layout:
  // {wrEn, wrData[5:0], gainPin, gainBus[4:0], wideband, expAmp[4:0], expRd[5:0]}
  localparam int NV = 17;
  localparam logic [24:0] VECS [NV] = '{
    {1'b0, 6'h00, 1'b1, 5'h07, 1'b0, 5'h07, 6'h07}, // 0  R3 pin capture
    {1'b0, 6'h00, 1'b0, 5'h1F, 1'b0, 5'h07, 6'h07}, // 1  R4 strobe low
    {1'b0, 6'h00, 1'b1, 5'h1E, 1'b0, 5'h15, 6'h15}, // 2  R6 pin saturate
    {1'b0, 6'h00, 1'b0, 5'h00, 1'b1, 5'h12, 6'h12}, // 3  R7 clamp
    {1'b0, 6'h00, 1'b0, 5'h00, 1'b0, 5'h15, 6'h15}, // 4  R8 restore
    {1'b1, 6'h2A, 1'b0, 5'h00, 1'b0, 5'h0A, 6'h2A}, // 5  R2 register write
    {1'b0, 6'h00, 1'b1, 5'h03, 1'b0, 5'h0A, 6'h2A}, // 6  R4 register mode
    {1'b1, 6'h3F, 1'b0, 5'h00, 1'b0, 5'h15, 6'h35}, // 7  R6 register saturate
    {1'b0, 6'h00, 1'b0, 5'h00, 1'b1, 5'h12, 6'h32}, // 8  R7 R9 clamp readback
    {1'b1, 6'h33, 1'b0, 5'h00, 1'b1, 5'h12, 6'h32}, // 9  R7 write under clamp
    {1'b0, 6'h00, 1'b0, 5'h00, 1'b0, 5'h13, 6'h33}, // 10 R8 restore
    {1'b1, 6'h05, 1'b0, 5'h00, 1'b0, 5'h13, 6'h13}, // 11 R5 switch to pins
    {1'b1, 6'h21, 1'b1, 5'h02, 1'b0, 5'h01, 6'h21}, // 12 R10 write wins
    {1'b1, 6'h00, 1'b1, 5'h09, 1'b0, 5'h01, 6'h01}, // 13 R10 R5 write wins
    {1'b0, 6'h00, 1'b1, 5'h12, 1'b1, 5'h12, 6'h12}, // 14 R7 boundary
    {1'b0, 6'h00, 1'b1, 5'h15, 1'b0, 5'h15, 6'h15}, // 15 R6 boundary
    {1'b0, 6'h00, 1'b1, 5'h11, 1'b1, 5'h11, 6'h11}  // 16 R7 below limit
  };

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  initial begin
    // R1: reset state while reset is asserted.
    #5;
    check("R1 amp in reset", {1'b0, ampGain}, 6'h00);
    check("R1 read in reset", regRdData, 6'h00);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 amp after reset", {1'b0, ampGain}, 6'h00);
    check("R1 read after reset", regRdData, 6'h00);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      regWrEn   = VECS[i][24];
      regWrData = VECS[i][23:18];
      gainPin   = VECS[i][17];
      gainBus   = VECS[i][16:12];
      wideband  = VECS[i][11];
      @(posedge clk);
      #1;
      check($sformatf("vector %0d ampGain", i), {1'b0, ampGain}, {1'b0, VECS[i][10:6]});
      check($sformatf("vector %0d regRdData", i), regRdData, VECS[i][5:0]);
      // R9: the readback low bits always equal the applied gain.
      check("R9 readback tracks ampGain", {1'b0, regRdData[4:0]}, {1'b0, ampGain});
      regWrEn = 1'b0;
      gainPin = 1'b0;
    end

    // R1: a reset in the middle of a run returns to the reset state.
    @(negedge clk);
    regWrData = 6'h2C;
    regWrEn   = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    rstN    = 1'b0;
    #1;
    check("R1 amp on mid-run reset", {1'b0, ampGain}, 6'h00);
    check("R1 read on mid-run reset", regRdData, 6'h00);
    @(negedge clk);
    rstN = 1'b1;

    // R3: after the reset, pin mode is active again.
    gainBus = 5'h04;
    gainPin = 1'b1;
    @(posedge clk);
    #1;
    check("R3 pin mode after reset", regRdData, 6'h04);
    gainPin = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // Watchdog: a hung run counts as one failed check.
  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule